// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block forms the product of two 32-bit binary floating-point operands (1 sign bit, 8 exponent bits, 23 fraction bits, exponent bias 127) in a two-stage pipeline. The first stage decodes both operands, resolves special values, takes the XOR of the signs, adds the biased exponents less one bias and multiplies the 24-bit significands. The second stage normalises the 48-bit product with at most one right shift. It then rounds it under a caller-chosen mode, packs the result and raises the exception flags.

A request is offered by raising `in_valid` with the operands and a rounding mode. The answer appears on the outputs with `out_valid` exactly two clock edges later, and a new request may be offered on every cycle. Operands whose exponent field is zero are treated as signed zero. Results too small for a normal number are flushed to signed zero. No traps are taken: every exceptional case returns a defined value and sets the matching flag.

Top module: `fmul_sp`

## Requirements
- R1: A request accepted with `in_valid` high on a rising edge produces `out_valid` high, with its result and flags, after the second rising edge that follows. `out_valid` is low in every other cycle.
- R2: For every result that is not a NaN, the sign bit (bit 31) equals the XOR of the operand sign bits, including zero, infinity, overflow and underflow results.
- R3: For two normal operands with an exact in-range product, the result exponent field is the sum of the operand exponent fields minus 127 and the fraction is the exact product (for example 0x3FC00000 times 0x40000000 gives 0x40400000), with no flag set.
- R4: When the significand product is 2 or more, it is shifted right one place and the exponent is incremented (0x3FC00000 times 0x3FC00000 gives 0x40100000).
- R5: With `rmode` = 0 (nearest, ties to even), the bit below the kept 24 bits is the guard bit. The bit below it is the round bit, and all lower bits OR together into sticky. The result is incremented when guard is set and any of round, sticky or the kept LSB is set. An exact tie therefore goes to the even neighbour.
- R6: With `rmode` = 1 the result is truncated toward zero. With `rmode` = 2 the magnitude is incremented if any discarded bit is set and the result is positive. With `rmode` = 3 it is incremented if any discarded bit is set and the result is negative. A carry out of the rounded significand renormalises and increments the exponent.
- R7: `flag_inexact` is set exactly when rounding discards a non-zero bit, or when the result overflows or underflows. It is clear for exact results.
- R8: If the exponent after normalisation and rounding is 255 or more, the result is infinity with the R2 sign, and `flag_overflow` and `flag_inexact` are set. A result exponent of exactly 254 is returned normally.
- R9: If the exponent after rounding is 0 or less, the result is zero with the R2 sign, and `flag_underflow` and `flag_inexact` are set. Operands with exponent field 0 count as zero and raise no flag.
- R10: Zero (or a flushed subnormal) times infinity returns the canonical NaN 0x7FC00000 with only `flag_invalid` set.
- R11: Any NaN operand (exponent 255, non-zero fraction) returns 0x7FC00000 with no flag. Otherwise, infinity times a non-zero value returns infinity and zero times a finite value returns zero, each with the R2 sign and no flag.
- R12: While `rst_n` is low, `out_valid` is low, and no result is produced for cycles before reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rmode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result and flags are valid |
| out_result | output | 32 | Packed product |
| flag_invalid | output | 1 | Zero times infinity |
| flag_overflow | output | 1 | Result too large, infinity returned |
| flag_underflow | output | 1 | Result too small, zero returned |
| flag_inexact | output | 1 | Result differs from the exact product |

## Verification
The bench builds the block with its default widths, an 8-bit exponent and a 23-bit fraction. With these, the 48-bit product places guard, round and sticky at the true single-precision positions. Hand-computed operand pairs therefore reach exact ties, directed rounding of negative values, the largest and smallest normal results, and both flush boundaries. A deterministic pseudo-random stream under all four rounding modes then drives operands across the full exponent range, so overflow, underflow and special operands also arise back-to-back in the pipeline.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fflags_t;

  // Increment decision for the kept significand.
  function automatic logic round_inc(input rmode_e rm, input logic sign,
                                     input logic lsb, input logic guard,
                                     input logic rnd, input logic sticky);
    logic lost;
    lost = guard | rnd | sticky;
    case (rm)
      RM_NEAR_EVEN: round_inc = guard & (rnd | sticky | lsb);
      RM_TO_ZERO:   round_inc = 1'b0;
      RM_TO_POS:    round_inc = lost & ~sign;
      default:      round_inc = lost & sign;
    endcase
  endfunction

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      op,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W:0]   sig,
  output logic              is_zero,
  output logic              is_inf,
  output logic              is_nan
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max;

  assign sign    = op[W-1];
  assign exp_f   = op[W-2:FRAC_W];
  assign frac    = op[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign is_zero = (exp_f == '0);          // subnormals flush to zero
  assign is_inf  = exp_max & (frac == '0);
  assign is_nan  = exp_max & (frac != '0);
  assign sig     = is_zero ? '0 : {1'b1, frac};
endmodule

// File: rtl/fmul_round.sv
module fmul_round
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int PW    = 2 * SIG_W,
  localparam int XW    = EXP_W + 2
) (
  input  logic                 sign,
  input  logic signed [XW-1:0] exp_sum,
  input  logic [PW-1:0]        prod,
  input  rmode_e               rm,
  output logic [W-1:0]         res,
  output logic                 ovf,
  output logic                 unf,
  output logic                 inexact
);
  localparam logic signed [XW-1:0] EMAX_S = XW'((1 << EXP_W) - 1);

  logic              hi;
  logic [SIG_W-1:0]  kept;
  logic              g_bit, r_bit, s_bit, inc;
  logic [SIG_W:0]    rsum;
  logic              carry;
  logic [FRAC_W-1:0] frac_o;
  logic signed [XW-1:0] exp_n, exp_r;

  assign hi    = prod[PW-1];
  assign kept  = hi ? prod[PW-1:SIG_W] : prod[PW-2:SIG_W-1];
  assign g_bit = hi ? prod[SIG_W-1]    : prod[SIG_W-2];
  assign r_bit = hi ? prod[SIG_W-2]    : prod[SIG_W-3];
  assign s_bit = hi ? (|prod[SIG_W-3:0]) : (|prod[SIG_W-4:0]);
  assign exp_n = exp_sum + $signed({{(XW-1){1'b0}}, hi});

  assign inc    = round_inc(rm, sign, kept[0], g_bit, r_bit, s_bit);
  assign rsum   = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
  assign carry  = rsum[SIG_W];
  assign frac_o = carry ? rsum[SIG_W-1:1] : rsum[SIG_W-2:0];
  assign exp_r  = exp_n + $signed({{(XW-1){1'b0}}, carry});

  assign ovf     = (exp_r >= EMAX_S);
  assign unf     = (exp_r <= 0);
  assign inexact = g_bit | r_bit | s_bit | ovf | unf;

  always_comb begin
    if (ovf)      res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf) res = {sign, {(W-1){1'b0}}};
    else          res = {sign, exp_r[EXP_W-1:0], frac_o};
  end
endmodule

// File: rtl/fmul_sp.sv
module fmul_sp
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int PW    = 2 * SIG_W,
  localparam int XW    = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   rmode,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         flag_invalid,
  output logic         flag_overflow,
  output logic         flag_underflow,
  output logic         flag_inexact
);
  localparam logic signed [XW-1:0] BIAS_S = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // operand decode
  logic [EXP_W-1:0] ea, eb;
  logic [FRAC_W:0]  ma, mb;
  logic sa, sb, za, zb, ia, ib, na, nb;

  fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .op(op_a), .sign(sa), .exp_f(ea), .sig(ma), .is_zero(za), .is_inf(ia), .is_nan(na));
  fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .op(op_b), .sign(sb), .exp_f(eb), .sig(mb), .is_zero(zb), .is_inf(ib), .is_nan(nb));

  // special-operand resolution
  logic         p_sign, any_nan, zero_inf, sp_hit;
  logic [W-1:0] sp_res;
  assign p_sign   = sa ^ sb;
  assign any_nan  = na | nb;
  assign zero_inf = (za & ib) | (ia & zb);
  assign sp_hit   = any_nan | ia | ib | za | zb;

  always_comb begin
    if (any_nan | zero_inf) sp_res = QNAN;
    else if (ia | ib)       sp_res = {p_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else                    sp_res = {p_sign, {(W-1){1'b0}}};
  end

  // stage 1 registers
  logic                 s1_valid, s1_sign, s1_sp, s1_inv;
  logic signed [XW-1:0] s1_exp;
  logic [PW-1:0]        s1_prod;
  logic [W-1:0]         s1_sp_res;
  rmode_e               s1_rm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_sign   <= 1'b0;
      s1_sp     <= 1'b0;
      s1_inv    <= 1'b0;
      s1_exp    <= '0;
      s1_prod   <= '0;
      s1_sp_res <= '0;
      s1_rm     <= RM_NEAR_EVEN;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign   <= p_sign;
        s1_sp     <= sp_hit;
        s1_inv    <= zero_inf & ~any_nan;
        s1_exp    <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S;
        s1_prod   <= ma * mb;
        s1_sp_res <= sp_res;
        s1_rm     <= rmode_e'(rmode);
      end
    end
  end

  // stage 2: normalise, round, pack
  logic [W-1:0] rnd_res;
  logic         rnd_ovf, rnd_unf, rnd_inx;

  fmul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign(s1_sign), .exp_sum(s1_exp), .prod(s1_prod), .rm(s1_rm),
    .res(rnd_res), .ovf(rnd_ovf), .unf(rnd_unf), .inexact(rnd_inx));

  // named events for the checker
  logic ovf_evt, unf_evt;
  assign ovf_evt = s1_valid & ~s1_sp & rnd_ovf;
  assign unf_evt = s1_valid & ~s1_sp & rnd_unf;

  fflags_t nxt_flags;
  always_comb begin
    if (s1_sp) nxt_flags = '{invalid: s1_inv, overflow: 1'b0, underflow: 1'b0, inexact: 1'b0};
    else       nxt_flags = '{invalid: 1'b0, overflow: rnd_ovf, underflow: rnd_unf, inexact: rnd_inx};
  end

  fflags_t out_flags;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result <= s1_sp ? s1_sp_res : rnd_res;
        out_flags  <= nxt_flags;
      end
    end
  end

  assign flag_invalid   = out_flags.invalid;
  assign flag_overflow  = out_flags.overflow;
  assign flag_underflow = out_flags.underflow;
  assign flag_inexact   = out_flags.inexact;
endmodule

// File: rtl/fmul_sp_chk.sv
module fmul_sp_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         s1_valid,
  input logic         ovf_evt,
  input logic         unf_evt,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         flag_invalid,
  input logic         flag_overflow,
  input logic         flag_underflow,
  input logic         flag_inexact
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic res_is_nan;
  assign res_is_nan = (&out_result[W-2:FRAC_W]) && (out_result[FRAC_W-1:0] != '0);

  AST_ACCEPT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);                                          // R1
  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);                                         // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);                                       // R1
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(s1_valid) && $past(in_valid, 2) && !res_is_nan)
      |-> out_result[W-1] == ($past(op_a[W-1], 2) ^ $past(op_b[W-1], 2))); // R2
  AST_FLUSH_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (flag_overflow || flag_underflow)) |-> flag_inexact);   // R7
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (flag_overflow && out_result[W-2:0] == INF_MAG));       // R8
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (flag_underflow && out_result[W-2:0] == '0));           // R9
  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (out_result == QNAN && !flag_inexact)); // R10
endmodule

bind fmul_sp fmul_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fmul_sp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .s1_valid(s1_valid), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
  .out_valid(out_valid), .out_result(out_result),
  .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
  .flag_underflow(flag_underflow), .flag_inexact(flag_inexact));

// File: tb/fmul_sp_bench.sv
module fmul_sp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  rmode = '0;
  logic        out_valid, flag_invalid, flag_overflow, flag_underflow, flag_inexact;
  logic [31:0] out_result;

  fmul_sp u_fmul_sp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rmode(rmode), .out_valid(out_valid), .out_result(out_result),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  bit [35:0] q_exp[$];
  int        q_cyc[$];
  string     q_tag[$];

  // Flags packed as {invalid, overflow, underflow, inexact, result}.
  function automatic bit [35:0] model(input bit [31:0] a, input bit [31:0] b, input bit [1:0] rm);
    bit sgn; bit [7:0] ea, eb; bit [22:0] fa, fb;
    bit nan_a, nan_b, inf_a, inf_b, z_a, z_b;
    bit [63:0] p; bit [24:0] keep; bit [23:0] rem; int e; bit up;
    sgn = a[31] ^ b[31];
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    nan_a = (ea == 8'hFF) && (fa != 0); nan_b = (eb == 8'hFF) && (fb != 0);
    inf_a = (ea == 8'hFF) && (fa == 0); inf_b = (eb == 8'hFF) && (fb == 0);
    z_a = (ea == 0); z_b = (eb == 0);
    if (nan_a || nan_b) return {4'b0000, 32'h7FC00000};
    if ((inf_a && z_b) || (z_a && inf_b)) return {4'b1000, 32'h7FC00000};
    if (inf_a || inf_b) return {4'b0000, sgn, 8'hFF, 23'h0};
    if (z_a || z_b) return {4'b0000, sgn, 31'h0};
    p = {40'h0, 1'b1, fa} * {40'h0, 1'b1, fb};
    e = int'(ea) + int'(eb) - 127;
    if (p >= 64'h8000_0000_0000) e = e + 1; else p = p << 1;
    keep = {1'b0, p[47:24]};
    rem  = p[23:0];
    case (rm)
      2'd0: up = (rem > 24'h800000) || (rem == 24'h800000 && keep[0]);
      2'd1: up = 1'b0;
      2'd2: up = (rem != 0) && !sgn;
      default: up = (rem != 0) && sgn;
    endcase
    keep = keep + 25'(up);
    if (keep[24]) begin keep = keep >> 1; e = e + 1; end
    if (e >= 255) return {4'b0101, sgn, 8'hFF, 23'h0};
    if (e <= 0)   return {4'b0011, sgn, 31'h0};
    return {3'b000, rem != 0, sgn, 8'(e), keep[22:0]};
  endfunction

  task automatic push(input bit [31:0] a, input bit [31:0] b, input bit [1:0] rm,
                      input bit [35:0] expv, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; op_a = a; op_b = b; rmode = rm;
    q_exp.push_back(expv); q_cyc.push_back(cyc + 2); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      n_tests++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R1: out_valid with nothing pending, actual=1 expected=0");
      end else begin
        bit [35:0] e; int c; string t; bit [35:0] got;
        e = q_exp.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
        got = {flag_invalid, flag_overflow, flag_underflow, flag_inexact, out_result};
        if (c != cyc) begin
          n_fail++;
          $display("FAIL R1 (%s): result at cycle %0d, expected cycle %0d", t, cyc, c);
        end else if (got !== e) begin
          n_fail++;
          $display("FAIL %s: actual flags=%b res=%h expected flags=%b res=%h",
                   t, got[35:32], got[31:0], e[35:32], e[31:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] x;
    // R12: reset holds out_valid low even with a request present
    in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
    repeat (4) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R12: out_valid during reset actual=%b expected=0", out_valid);
    end
    in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R12: out_valid after reset actual=%b expected=0", out_valid);
    end

    // R3 exact products
    push(32'h3FC00000, 32'h40000000, 2'd0, {4'b0000, 32'h40400000}, "R3");
    push(32'h3FC00000, 32'h40000000, 2'd2, {4'b0000, 32'h40400000}, "R7");
    // R4 normalisation shift
    push(32'h3FC00000, 32'h3FC00000, 2'd0, {4'b0000, 32'h40100000}, "R4");
    // R5 ties
    push(32'h3F800001, 32'h3FC00000, 2'd0, {4'b0001, 32'h3FC00002}, "R5");
    push(32'h3F800003, 32'h3FC00000, 2'd0, {4'b0001, 32'h3FC00004}, "R5");
    // R6 directed modes
    push(32'h3F800001, 32'h3FC00000, 2'd1, {4'b0001, 32'h3FC00001}, "R6");
    push(32'h3F800001, 32'h3FC00000, 2'd2, {4'b0001, 32'h3FC00002}, "R6");
    push(32'hBF800001, 32'h3FC00000, 2'd2, {4'b0001, 32'hBFC00001}, "R6");
    push(32'hBF800001, 32'h3FC00000, 2'd3, {4'b0001, 32'hBFC00002}, "R6");
    push(32'h3F800003, 32'h3FC00000, 2'd2, {4'b0001, 32'h3FC00005}, "R6");
    // R8 overflow and its boundary
    push(32'h7F000000, 32'h40000000, 2'd0, {4'b0101, 32'h7F800000}, "R8");
    push(32'hFF000000, 32'h40000000, 2'd1, {4'b0101, 32'hFF800000}, "R8");
    push(32'h7F000000, 32'h3FFFFFFF, 2'd0, {4'b0000, 32'h7F7FFFFF}, "R8");
    // R9 underflow, flush, boundary
    push(32'h00800000, 32'h00800000, 2'd0, {4'b0011, 32'h00000000}, "R9");
    push(32'h80800000, 32'h00800000, 2'd0, {4'b0011, 32'h80000000}, "R9");
    push(32'h00800000, 32'h3F000000, 2'd0, {4'b0011, 32'h00000000}, "R9");
    push(32'h00800000, 32'h3F800000, 2'd0, {4'b0000, 32'h00800000}, "R9");
    push(32'h00000001, 32'h3F800000, 2'd0, {4'b0000, 32'h00000000}, "R9");
    push(32'h80000001, 32'h3F800000, 2'd0, {4'b0000, 32'h80000000}, "R9");
    // R10 zero times infinity
    push(32'h00000000, 32'h7F800000, 2'd0, {4'b1000, 32'h7FC00000}, "R10");
    push(32'h7F800000, 32'h80000000, 2'd3, {4'b1000, 32'h7FC00000}, "R10");
    // R11 other specials, R2 signs
    push(32'h7FC00001, 32'h3F800000, 2'd0, {4'b0000, 32'h7FC00000}, "R11");
    push(32'h7F800001, 32'h00000000, 2'd0, {4'b0000, 32'h7FC00000}, "R11");
    push(32'h7F800000, 32'hC0000000, 2'd0, {4'b0000, 32'hFF800000}, "R11");
    push(32'h80000000, 32'h40A00000, 2'd0, {4'b0000, 32'h80000000}, "R2");
    push(32'hC0000000, 32'hC0400000, 2'd0, {4'b0000, 32'h40C00000}, "R2");
    idle();
    idle();

    // pseudo-random stream, all modes, model-computed (R3 R5 R6 R7)
    x = 32'h2545F491;
    for (int i = 0; i < 600; i++) begin
      bit [31:0] a, b;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5; a = x;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5; b = x;
      if (i % 4 != 0) begin
        a[30:23] = 8'd96 + {1'b0, a[29:23] >> 1};
        b[30:23] = 8'd96 + {1'b0, b[29:23] >> 1};
      end
      push(a, b, 2'(i), model(a, b, 2'(i)), "R6");
      if (i % 37 == 0) idle();
    end
    idle();
    repeat (6) @(posedge clk);

    n_tests++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results missing, actual=%0d expected=0", q_exp.size(), q_exp.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule